// File: doc/BRIEF.md
# Trace Buffer JTAG Register Port

This block connects the debug scan path to the control and data registers of an on-chip trace capture buffer. It is clocked by the test clock and follows the capture, shift and update strobes of an external TAP controller. It also watches the instruction that the TAP currently holds. Two instructions matter to it:

- **Chain select (0x2):** a five-bit chain-select register sits between TDI and TDO.
- **Chain access (0xC):** the selected chain is connected.

Chain 0 is a 40-bit access word. When an access word is updated, it becomes a single write or read on a simple register-file bus toward the buffer core. That core holds nine 32-bit registers at addresses 0 to 8. Every other chain, and every other instruction, sees a one-bit bypass path.

Reads are pipelined. The update of a read scan only issues the read strobe. The value comes out during the next scan. The capture of that next scan places the word in the data field, and it is then shifted out while the next request is shifted in. A read of the RAM-data address moves the core's read pointer forward. So a host reading a run of trace words requests that address on each scan and requests address 0 on the last one. This collects the final word without consuming another entry.

An access state machine with four states drives the bus side:

- **IDLE:** nothing is outstanding.
- **WRITE:** the write strobe cycle.
- **READ:** the read strobe cycle, in which the read data is sampled.
- **RESULT:** a read word is held until the next capture.

The transitions are:

- IDLE or RESULT to WRITE, on the update of a legal write.
- IDLE or RESULT to READ, on the update of a legal read.
- IDLE or RESULT to RESULT, on the update of a read to an illegal address. The held word is then zero.
- IDLE or RESULT to IDLE, on the update of a write to an illegal address.
- RESULT to IDLE, on a capture.
- WRITE to IDLE, unconditionally.
- READ to RESULT, unconditionally.

Top module: `trace_reg_jtag_port`

## Requirements
- R1: After reset:
  - tdo is low and neither rf_we nor rf_re is asserted.
  - The selected chain is 0.
  - No read result is outstanding, so the first access scan shifts out all zeros.
- R2: Under instruction 0x2, Capture-DR loads the five-bit pattern 10000 into the chain-select register, which is shifted LSB first. Update-DR makes the shifted value the selected chain.
- R3: Under instruction 0xC with a selected chain other than 0, and under any instruction other than 0x2 and 0xC, TDI and TDO are joined by a one-bit path. Capture loads 0 into it, and the bit on TDI appears on TDO after one shift.
- R4: Under instruction 0xC with chain 0 selected, the access word is 40 bits, shifted LSB first, and tdo shows its bit 0. The fields are:
  - bits 31:0: data.
  - bits 38:32: register address.
  - bit 39: direction, where 1 is write and 0 is read.
- R5: Update-DR of an access word with bit 39 set and an address below 9 produces exactly one rf_we cycle. That cycle comes on the clock after the update and carries the address on rf_addr and the data on rf_wdata.
- R6: Update-DR of an access word with bit 39 clear and an address below 9 produces exactly one rf_re cycle, on the clock after the update, with the address on rf_addr. rf_rdata is sampled in that cycle.
- R7: The next Capture-DR on chain 0 loads the sampled read word into bits 31:0 and zeros into bits 39:32. The word of each read therefore leaves during the following scan, including across a burst of reads.
- R8: A Capture-DR on chain 0 with no outstanding read loads all zeros. A read word is delivered by one capture only.
- R9: An access word with address 9 or higher produces no strobe. If it is a read, the following scan shifts out zero.
- R10: Update-DR while the access chain 0 is not connected produces no strobe and leaves the core registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 4 | Instruction currently held by the TAP |
| capture_dr | input | 1 | Capture-DR strobe, one cycle |
| shift_dr | input | 1 | Shift-DR strobe, one cycle per bit |
| update_dr | input | 1 | Update-DR strobe, one cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| rf_addr | output | 7 | Register address toward the buffer core |
| rf_wdata | output | 32 | Write data toward the buffer core |
| rf_we | output | 1 | One-cycle write strobe |
| rf_re | output | 1 | One-cycle read strobe |
| rf_rdata | input | 32 | Read data from the core, valid while rf_re is high |

## Verification
The bench aims first at the one-scan read latency. A design that captured the word requested in the current scan, or that delivered a held word twice, would shift out the wrong register in the read-then-identify pair. It would also return trace entries offset by one in a burst of RAM-data reads. The final read-pointer value exposes any extra or missing RAM-data strobe. Scans that address locations 9 and above, scans through a non-zero chain, and scans under an unrelated instruction show whether the design lets a strobe leak or leaves a stale word behind. Reading the chain-select capture pattern and the bypass bit catches a swapped bit order or a wrong capture value.

// File: rtl/trace_reg_pkg.sv
package trace_reg_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 7;
    localparam int CHAIN_W  = 5;
    localparam int INSTR_W  = 4;
    localparam int NUM_REGS = 9;
    localparam int DR_W     = DATA_W + ADDR_W + 1;

    localparam logic [INSTR_W-1:0] INS_CHAIN_SEL    = 4'h2;
    localparam logic [INSTR_W-1:0] INS_CHAIN_ACCESS = 4'hC;

    localparam logic [CHAIN_W-1:0] CHAIN_CAPTURE = 5'b10000;
    localparam logic [CHAIN_W-1:0] REG_CHAIN     = '0;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_WRITE  = 2'd1,
        ACC_READ   = 2'd2,
        ACC_RESULT = 2'd3
    } acc_state_e;

endpackage

// File: rtl/trace_chain_select.sv
module trace_chain_select #(
    parameter int                 SEL_W   = 5,
    parameter logic [SEL_W-1:0]   CAP_VAL = 5'b10000
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             en,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic             tdi,
    output logic [SEL_W-1:0] chain_q,
    output logic             sr_lsb
);

    logic [SEL_W-1:0] sr_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            chain_q <= '0;
        end else if (en) begin
            if (capture) begin
                sr_q <= CAP_VAL;
            end else if (shift) begin
                sr_q <= {tdi, sr_q[SEL_W-1:1]};
            end else if (update) begin
                chain_q <= sr_q;
            end
        end
    end

    assign sr_lsb = sr_q[0];

endmodule

// File: rtl/trace_bypass_bit.sv
module trace_bypass_bit (
    input  logic tck,
    input  logic rst_n,
    input  logic en,
    input  logic capture,
    input  logic shift,
    input  logic tdi,
    output logic bit_q
);

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (en) begin
            if (capture) begin
                bit_q <= 1'b0;
            end else if (shift) begin
                bit_q <= tdi;
            end
        end
    end

endmodule

// File: rtl/trace_data_shifter.sv
module trace_data_shifter #(
    parameter int WORD_W = 32,
    parameter int TOT_W  = 40
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              en,
    input  logic              capture,
    input  logic              shift,
    input  logic              tdi,
    input  logic [WORD_W-1:0] cap_word,
    output logic [TOT_W-1:0]  dr_q
);

    localparam int PAD_W = TOT_W - WORD_W;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else if (en) begin
            if (capture) begin
                dr_q <= {{PAD_W{1'b0}}, cap_word};
            end else if (shift) begin
                dr_q <= {tdi, dr_q[TOT_W-1:1]};
            end
        end
    end

endmodule

// File: rtl/trace_access_fsm.sv
module trace_access_fsm
    import trace_reg_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int NREGS = NUM_REGS
) (
    input  logic          tck,
    input  logic          rst_n,
    input  logic          upd_hit,
    input  logic          cap_hit,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_write,
    input  logic [DW-1:0] rf_rdata,
    output logic          rf_we,
    output logic          rf_re,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    output logic [DW-1:0] cap_word
);

    acc_state_e    state_q;
    acc_state_e    state_d;
    logic [DW-1:0] hold_q;
    logic          addr_ok;

    assign addr_ok = (req_addr < AW'(NREGS));

    // state register
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE, ACC_RESULT: begin
                if (upd_hit) begin
                    if (addr_ok) begin
                        state_d = req_write ? ACC_WRITE : ACC_READ;
                    end else begin
                        state_d = req_write ? ACC_IDLE : ACC_RESULT;
                    end
                end else if (cap_hit) begin
                    state_d = ACC_IDLE;
                end
            end
            ACC_WRITE:  state_d = ACC_IDLE;
            ACC_READ:   state_d = ACC_RESULT;
        endcase
    end

    // outputs
    always_comb begin
        rf_we    = (state_q == ACC_WRITE);
        rf_re    = (state_q == ACC_READ);
        cap_word = (state_q == ACC_RESULT) ? hold_q : '0;
    end

    // request and result datapath
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            rf_addr  <= '0;
            rf_wdata <= '0;
            hold_q   <= '0;
        end else begin
            if (upd_hit && addr_ok) begin
                rf_addr  <= req_addr;
                rf_wdata <= req_data;
            end
            if (state_q == ACC_READ) begin
                hold_q <= rf_rdata;
            end else if (upd_hit && !req_write && !addr_ok) begin
                hold_q <= '0;
            end
        end
    end

endmodule

// File: rtl/trace_reg_jtag_port.sv
module trace_reg_jtag_port
    import trace_reg_pkg::*;
(
    input  logic              tck,
    input  logic              rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    output logic              rf_re,
    input  logic [DATA_W-1:0] rf_rdata
);

    localparam int DIR_BIT  = DR_W - 1;
    localparam int ADDR_LSB = DATA_W;

    logic [CHAIN_W-1:0] chain;
    logic               sel_lsb;
    logic               byp_q;
    logic [DR_W-1:0]    dr_q;
    logic [DATA_W-1:0]  cap_word;
    logic               on_sel;
    logic               on_access;
    logic               on_bypass;

    assign on_sel    = (instr == INS_CHAIN_SEL);
    assign on_access = (instr == INS_CHAIN_ACCESS) && (chain == REG_CHAIN);
    assign on_bypass = !on_sel && !on_access;

    trace_chain_select #(
        .SEL_W   (CHAIN_W),
        .CAP_VAL (CHAIN_CAPTURE)
    ) u_chain_sel (
        .tck     (tck),
        .rst_n   (rst_n),
        .en      (on_sel),
        .capture (capture_dr),
        .shift   (shift_dr),
        .update  (update_dr),
        .tdi     (tdi),
        .chain_q (chain),
        .sr_lsb  (sel_lsb)
    );

    trace_bypass_bit u_bypass (
        .tck     (tck),
        .rst_n   (rst_n),
        .en      (on_bypass),
        .capture (capture_dr),
        .shift   (shift_dr),
        .tdi     (tdi),
        .bit_q   (byp_q)
    );

    trace_data_shifter #(
        .WORD_W (DATA_W),
        .TOT_W  (DR_W)
    ) u_shifter (
        .tck      (tck),
        .rst_n    (rst_n),
        .en       (on_access),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .tdi      (tdi),
        .cap_word (cap_word),
        .dr_q     (dr_q)
    );

    trace_access_fsm #(
        .DW    (DATA_W),
        .AW    (ADDR_W),
        .NREGS (NUM_REGS)
    ) u_fsm (
        .tck       (tck),
        .rst_n     (rst_n),
        .upd_hit   (update_dr && on_access),
        .cap_hit   (capture_dr && on_access),
        .req_addr  (dr_q[ADDR_LSB +: ADDR_W]),
        .req_data  (dr_q[DATA_W-1:0]),
        .req_write (dr_q[DIR_BIT]),
        .rf_rdata  (rf_rdata),
        .rf_we     (rf_we),
        .rf_re     (rf_re),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .cap_word  (cap_word)
    );

    always_comb begin
        if (on_sel) begin
            tdo = sel_lsb;
        end else if (on_access) begin
            tdo = dr_q[0];
        end else begin
            tdo = byp_q;
        end
    end

endmodule

// File: rtl/trace_reg_jtag_port_chk.sv
module trace_reg_jtag_port_chk
    import trace_reg_pkg::*;
(
    input logic               tck,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic               update_dr,
    input logic               rf_we,
    input logic               rf_re,
    input logic [ADDR_W-1:0]  rf_addr
);

    assert_one_strobe_R5: assert property (@(posedge tck) disable iff (!rst_n)
        !(rf_we && rf_re));

    assert_we_after_update_R5: assert property (@(posedge tck) disable iff (!rst_n)
        rf_we |-> ($past(update_dr) && $past(instr) == INS_CHAIN_ACCESS));

    assert_re_after_update_R6: assert property (@(posedge tck) disable iff (!rst_n)
        rf_re |-> ($past(update_dr) && $past(instr) == INS_CHAIN_ACCESS));

    assert_single_pulse_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (rf_we || rf_re) |=> !(rf_we || rf_re));

    assert_addr_legal_R9: assert property (@(posedge tck) disable iff (!rst_n)
        (rf_we || rf_re) |-> (rf_addr < ADDR_W'(NUM_REGS)));

    assert_quiet_off_chain_R10: assert property (@(posedge tck) disable iff (!rst_n)
        (update_dr && instr != INS_CHAIN_ACCESS) |=> !(rf_we || rf_re));

endmodule

bind trace_reg_jtag_port trace_reg_jtag_port_chk u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .instr     (instr),
    .update_dr (update_dr),
    .rf_we     (rf_we),
    .rf_re     (rf_re),
    .rf_addr   (rf_addr)
);

// File: tb/trace_reg_jtag_port_bench.sv
module trace_reg_jtag_port_bench;

    localparam time HALF = 10ns;
    localparam logic [3:0] I_SEL = 4'h2;
    localparam logic [3:0] I_ACC = 4'hC;
    localparam logic [31:0] ID_VAL = 32'h0B1D_7EA5;

    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  instr = 4'h0;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [6:0]  rf_addr;
    logic [31:0] rf_wdata;
    logic        rf_we;
    logic        rf_re;
    logic [31:0] rf_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #HALF tck = ~tck;

    trace_reg_jtag_port u_trace_reg_jtag_port (
        .tck(tck), .rst_n(rst_n), .instr(instr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re),
        .rf_rdata(rf_rdata)
    );

    // buffer core stand-in: nine registers, address 4 reads trace RAM and advances the pointer
    logic [31:0] regs [0:8];
    logic [31:0] rptr;

    function automatic logic [31:0] core_val(input logic [6:0] a);
        if (a == 7'd4) return 32'hA500_0000 | rptr;
        if (a == 7'd5) return rptr;
        if (a < 7'd9) return regs[a];
        return 32'h0;
    endfunction

    assign rf_rdata = rf_re ? core_val(rf_addr) : 32'h0;

    always @(posedge tck) begin
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) regs[i] <= 32'h0;
            regs[0] <= ID_VAL;
            regs[1] <= 32'd16;
            regs[2] <= 32'd24;
            rptr <= 32'h0;
        end else begin
            if (rf_we && rf_addr < 7'd9) begin
                if (rf_addr == 7'd5) rptr <= rf_wdata;
                else regs[rf_addr] <= rf_wdata;
            end
            if (rf_re && rf_addr == 7'd4) rptr <= rptr + 32'd1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    logic [4:0]  m_chain, m_sel;
    logic [39:0] m_dr;
    logic        m_byp;
    logic [31:0] m_hold;
    logic        e_we, e_re, e_tdo, n_we, n_re, m_acc;
    logic [6:0]  e_addr;
    logic [31:0] e_data;

    always @(posedge tck) begin
        if (!rst_n) begin
            m_chain = 0; m_sel = 0; m_dr = 0; m_byp = 0; m_hold = 0;
            e_we = 0; e_re = 0; e_addr = 0; e_data = 0; e_tdo = 0;
        end else begin
            if (e_re) m_hold = core_val(e_addr);
            n_we = 0;
            n_re = 0;
            m_acc = (instr == I_ACC) && (m_chain == 5'd0);
            if (instr == I_SEL) begin
                if (capture_dr) m_sel = 5'b10000;
                else if (shift_dr) m_sel = {tdi, m_sel[4:1]};
                else if (update_dr) m_chain = m_sel;
            end else if (m_acc) begin
                if (capture_dr) begin
                    m_dr = {8'h0, m_hold};
                    m_hold = 0;
                end else if (shift_dr) begin
                    m_dr = {tdi, m_dr[39:1]};
                end else if (update_dr) begin
                    if (m_dr[38:32] < 7'd9) begin
                        if (m_dr[39]) n_we = 1; else n_re = 1;
                        e_addr = m_dr[38:32];
                        e_data = m_dr[31:0];
                    end else if (!m_dr[39]) begin
                        m_hold = 0;
                    end
                end
            end else begin
                if (capture_dr) m_byp = 0;
                else if (shift_dr) m_byp = tdi;
            end
            e_we = n_we;
            e_re = n_re;
            m_acc = (instr == I_ACC) && (m_chain == 5'd0);
            e_tdo = (instr == I_SEL) ? m_sel[0] : (m_acc ? m_dr[0] : m_byp);
        end
    end

    always @(negedge tck) begin
        if (rst_n && !done) begin
            chk(tdo === e_tdo, "R4 tdo vs model", {63'h0, tdo}, {63'h0, e_tdo});
            chk(rf_we === e_we, "R5 write strobe", {63'h0, rf_we}, {63'h0, e_we});
            chk(rf_re === e_re, "R6 read strobe", {63'h0, rf_re}, {63'h0, e_re});
            if (e_we) begin
                chk(rf_addr === e_addr, "R5 write address", {57'h0, rf_addr}, {57'h0, e_addr});
                chk(rf_wdata === e_data, "R5 write data", {32'h0, rf_wdata}, {32'h0, e_data});
            end
            if (e_re) chk(rf_addr === e_addr, "R6 read address", {57'h0, rf_addr}, {57'h0, e_addr});
        end
    end

    task automatic tick();
        @(negedge tck);
        #1;
    endtask

    task automatic scan(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        tick();
        capture_dr = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick();
            capture_dr = 1'b0;
            shift_dr = 1'b1;
            dout[i] = tdo;
            tdi = din[i];
        end
        tick();
        shift_dr = 1'b0;
        tdi = 1'b0;
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
        tick();
        tick();
    endtask

    function automatic logic [63:0] aw(input logic rw, input logic [6:0] a, input logic [31:0] d);
        return {24'h0, rw, a, d};
    endfunction

    initial begin : watchdog
        #(2 * HALF * 100000);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] d;
        repeat (3) tick();
        chk(tdo === 1'b0, "R1 tdo after reset", {63'h0, tdo}, 64'h0);
        chk(!rf_we && !rf_re, "R1 strobes after reset", {62'h0, rf_we, rf_re}, 64'h0);
        rst_n = 1'b1;
        instr = I_ACC;
        tick();
        chk(tdo === 1'b0, "R1 tdo after release", {63'h0, tdo}, 64'h0);

        scan(40, aw(1, 7'd7, 32'h1234_5678), d);
        chk(d[39:0] == 40'h0, "R1 chain 0 selected, nothing pending", d, 64'h0);
        chk(regs[7] == 32'h1234_5678, "R5 register written", {32'h0, regs[7]}, 64'h1234_5678);
        scan(40, aw(0, 7'd7, 32'h0), d);
        chk(d[39:0] == 40'h0, "R8 capture after write is zero", d, 64'h0);
        scan(40, aw(0, 7'd0, 32'hFFFF_FFFF), d);
        chk(d[39:0] == 40'h00_1234_5678, "R7 pipelined read of reg 7", d, 64'h1234_5678);
        scan(40, aw(0, 7'd1, 32'h0), d);
        chk(d[39:0] == {8'h0, ID_VAL}, "R7 identification word", d, {32'h0, ID_VAL});
        scan(40, aw(0, 7'd0, 32'h0), d);
        chk(d[39:0] == 40'd16, "R7 depth word", d, 64'd16);

        scan(40, aw(1, 7'd12, 32'hDEAD_BEEF), d);
        scan(40, aw(0, 7'd12, 32'h0), d);
        chk(d[39:0] == 40'h0, "R8 capture after ignored write", d, 64'h0);
        scan(40, aw(0, 7'd0, 32'h0), d);
        chk(d[39:0] == 40'h0, "R9 read above map is zero", d, 64'h0);

        scan(40, aw(1, 7'd5, 32'd3), d);
        scan(40, aw(0, 7'd4, 32'h0), d);
        scan(40, aw(0, 7'd4, 32'h0), d);
        chk(d[31:0] == 32'hA500_0003, "R7 burst word 0", d, 64'hA500_0003);
        scan(40, aw(0, 7'd4, 32'h0), d);
        chk(d[31:0] == 32'hA500_0004, "R7 burst word 1", d, 64'hA500_0004);
        scan(40, aw(0, 7'd0, 32'h0), d);
        chk(d[31:0] == 32'hA500_0005, "R7 burst word 2", d, 64'hA500_0005);
        scan(40, aw(0, 7'd5, 32'h0), d);
        scan(40, aw(0, 7'd0, 32'h0), d);
        chk(d[31:0] == 32'd6, "R6 one pointer step per RAM read", d, 64'd6);

        instr = I_SEL;
        scan(5, 64'd1, d);
        chk(d[4:0] == 5'b10000, "R2 chain-select capture pattern", d, 64'h10);
        instr = I_ACC;
        scan(3, 64'b101, d);
        chk(d[2:0] == 3'b010, "R3 one-bit bypass on chain 1", d, 64'b010);
        scan(40, aw(1, 7'd7, 32'hAAAA_5555), d);
        chk(regs[7] == 32'h1234_5678, "R10 no write on chain 1", {32'h0, regs[7]}, 64'h1234_5678);

        instr = I_SEL;
        scan(5, 64'd0, d);
        instr = 4'hF;
        scan(40, aw(1, 7'd7, 32'h5555_AAAA), d);
        chk(regs[7] == 32'h1234_5678, "R10 no write under other instruction", {32'h0, regs[7]}, 64'h1234_5678);
        instr = I_ACC;
        scan(40, aw(0, 7'd7, 32'h0), d);
        scan(40, aw(0, 7'd0, 32'h0), d);
        chk(d[31:0] == 32'h1234_5678, "R10 register seen unchanged at port", d, 64'h1234_5678);

        tick();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule